// File: doc/BRIEF.md
# Register-Window Spill/Fill Counter Unit

This block keeps the bookkeeping for a windowed register file. It holds four window counters, a 6-bit window-state value and the current window pointer. On each cycle it takes one command: save, restore, flush-windows, saved, or restored. The command either moves the counters and the pointer or raises a trap. The trap type is built from the window-state value. It also depends on whether any windows still belong to another address space.

Software sees the window pointer in reversed order. The block turns reads and writes between that view and the internal pointer. A small write port loads any counter, the window-state value or the pointer, so trap handlers can restore context. Trap dispatch and the register storage itself sit outside this block.

Top module: `wnd_ctr_unit`

## Requirements
- R1: After reset: free-to-save count (`cansave`) = NWIN-2, clean count (`cleanwin`) = NWIN-1, restorable count (`canrestore`) = 0, other-space count (`otherwin`) = 0, window state = 0, internal pointer = 0, no trap.
- R2: A save with `cansave` = 0 raises a spill trap. The type is 0x080 | 0x020 | (state[5:3] << 2) when `otherwin` is nonzero, and 0x080 | (state[2:0] << 2) when it is zero.
- R3: A save with `cansave` nonzero and `cleanwin` equal to `canrestore` raises trap type 0x024.
- R4: Any other save decrements `cansave`, increments `canrestore`, and moves the internal pointer down by one modulo NWIN (0 goes to NWIN-1).
- R5: A restore with `canrestore` = 0 raises a fill trap. Its type uses the same composition as R2, on base 0x0C0. Otherwise a restore increments `cansave`, decrements `canrestore`, and moves the pointer up by one modulo NWIN.
- R6: Flush-windows raises a spill trap typed as in R2 when `cansave` is not NWIN-2. Otherwise it changes nothing.
- R7: Saved increments `cansave`. It then decrements `otherwin` if that count is nonzero; otherwise it decrements `canrestore`.
- R8: Restored increments `canrestore` and increments `cleanwin` only while `cleanwin` < NWIN-1. It then decrements `otherwin` if nonzero; otherwise it decrements `cansave`.
- R9: A trap shows on `trap_vld` and `trap_type` in the cycle after the command's clock edge, for one cycle. `trap_type` reads 0 when no trap is shown. A trapping command leaves all counters, the window state and the pointer unchanged.
- R10: `cwp_sw` reads NWIN-1 minus the internal pointer. A pointer write of value v stores NWIN-1 - (v mod NWIN).
- R11: With `wr_en` high, `wr_sel` picks the target: 0 `cansave`, 1 `canrestore`, 2 `otherwin`, 3 `cleanwin`, 4 window state (low 6 bits), 5 pointer (R10). Counters take the low bits of `wr_data`. Selectors 6 and 7 change nothing. A write overrides any command in the same cycle, and that command has no effect.
- R12: When several command pulses are high together, only one acts, in the order save, restore, flush, saved, restored.
- R13: Counter increments and decrements wrap modulo 2^clog2(NWIN).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| do_save | input | 1 | Save command pulse |
| do_restore | input | 1 | Restore command pulse |
| do_flush | input | 1 | Flush-windows command pulse |
| do_saved | input | 1 | Saved command pulse |
| do_restored | input | 1 | Restored command pulse |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target selector |
| wr_data | input | DW | Write value |
| cansave | output | clog2(NWIN) | Windows free to save |
| canrestore | output | clog2(NWIN) | Windows restorable |
| otherwin | output | clog2(NWIN) | Windows owned by another space |
| cleanwin | output | clog2(NWIN) | Clean windows |
| wstate | output | 6 | Window state value |
| cwp_int | output | clog2(NWIN) | Internal window pointer |
| cwp_sw | output | clog2(NWIN) | Software view of the pointer |
| trap_vld | output | 1 | Trap strobe |
| trap_type | output | 9 | Trap type |

## Verification
Some behaviour is checked by properties on every cycle. These properties cover:
- a spill trap on a save with no free window, and a fill trap on a restore with nothing to restore;
- the counter movement of a clean, untrapped save;
- that no counter or the pointer moves while a trap strobe is shown;
- that the clean count holds once it is saturated;
- that the pointer stays below NWIN.

Other behaviour only the bench scenarios can show. This covers the exact composed trap codes for both `otherwin` cases and the flush condition. It also covers the uneven saved/restored bookkeeping, wrap of the counters and of the pointer, the mod-NWIN reversed pointer write, write-over-command precedence and command priority.

// File: rtl/wnd_pkg.sv
package wnd_pkg;
  localparam int TTW = 9;
  localparam int WSW = 6;

  localparam logic [TTW-1:0] TT_SPILL = 9'h080;
  localparam logic [TTW-1:0] TT_FILL  = 9'h0C0;
  localparam logic [TTW-1:0] TT_OTHER = 9'h020;
  localparam logic [TTW-1:0] TT_CLEAN = 9'h024;

  typedef enum logic [2:0] {
    ACT_NONE     = 3'd0,
    ACT_SAVE     = 3'd1,
    ACT_RESTORE  = 3'd2,
    ACT_FLUSH    = 3'd3,
    ACT_SAVED    = 3'd4,
    ACT_RESTORED = 3'd5
  } act_e;

  typedef enum logic [2:0] {
    SEL_CANSAVE = 3'd0,
    SEL_CANREST = 3'd1,
    SEL_OTHER   = 3'd2,
    SEL_CLEAN   = 3'd3,
    SEL_WSTATE  = 3'd4,
    SEL_CWP     = 3'd5
  } wsel_e;
endpackage

// File: rtl/wnd_cmd_pick.sv
module wnd_cmd_pick
  import wnd_pkg::*;
(
  input  logic do_save,
  input  logic do_restore,
  input  logic do_flush,
  input  logic do_saved,
  input  logic do_restored,
  output act_e act
);
  // fixed priority: save, restore, flush, saved, restored (R12)
  always_comb begin
    if (do_save)          act = ACT_SAVE;
    else if (do_restore)  act = ACT_RESTORE;
    else if (do_flush)    act = ACT_FLUSH;
    else if (do_saved)    act = ACT_SAVED;
    else if (do_restored) act = ACT_RESTORED;
    else                  act = ACT_NONE;
  end
endmodule

// File: rtl/wnd_trap_type.sv
module wnd_trap_type
  import wnd_pkg::*;
#(
  parameter logic [TTW-1:0] BASE = TT_SPILL
) (
  input  logic [WSW-1:0] ws,
  input  logic           ow_nz,
  output logic [TTW-1:0] tt
);
  logic [TTW-1:0] sub_other, sub_norm;

  always_comb begin
    sub_other = TT_OTHER | TTW'({ws[5:3], 2'b00});
    sub_norm  = TTW'({ws[2:0], 2'b00});
    tt        = BASE | (ow_nz ? sub_other : sub_norm);
  end
endmodule

// File: rtl/wnd_cwp_ring.sv
module wnd_cwp_ring #(
  parameter int NWIN = 8,
  parameter int DW   = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic [CW-1:0] cwp,
  input  logic [DW-1:0] wr_val,
  output logic [CW-1:0] cwp_inc,
  output logic [CW-1:0] cwp_dec,
  output logic [CW-1:0] cwp_view,
  output logic [CW-1:0] cwp_from_view
);
  localparam logic [CW-1:0] TOP = CW'(NWIN - 1);

  logic [DW-1:0] wr_mod;

  always_comb begin
    cwp_inc       = (cwp == TOP) ? '0 : cwp + CW'(1);
    cwp_dec       = (cwp == '0) ? TOP : cwp - CW'(1);
    cwp_view      = TOP - cwp;
    wr_mod        = wr_val % DW'(NWIN);
    cwp_from_view = TOP - CW'(wr_mod);
  end
endmodule

// File: rtl/wnd_ctr_unit.sv
module wnd_ctr_unit
  import wnd_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           do_save,
  input  logic           do_restore,
  input  logic           do_flush,
  input  logic           do_saved,
  input  logic           do_restored,
  input  logic           wr_en,
  input  logic [2:0]     wr_sel,
  input  logic [DW-1:0]  wr_data,
  output logic [CW-1:0]  cansave,
  output logic [CW-1:0]  canrestore,
  output logic [CW-1:0]  otherwin,
  output logic [CW-1:0]  cleanwin,
  output logic [WSW-1:0] wstate,
  output logic [CW-1:0]  cwp_int,
  output logic [CW-1:0]  cwp_sw,
  output logic           trap_vld,
  output logic [TTW-1:0] trap_type
);
  localparam logic [CW-1:0] RST_CS = CW'(NWIN - 2);
  localparam logic [CW-1:0] RST_CL = CW'(NWIN - 1);
  localparam int NBASE = 2;

  logic [CW-1:0]  cs_q, cr_q, ow_q, cl_q, cwp_q;
  logic [CW-1:0]  cs_d, cr_d, ow_d, cl_d, cwp_d;
  logic [WSW-1:0] ws_q, ws_d;
  logic           trv_q, trv_d;
  logic [TTW-1:0] trt_q, trt_d;
  logic           st_en;

  act_e           act;
  wsel_e          sel;
  logic [CW-1:0]  cwp_inc, cwp_dec, cwp_view, cwp_wr;
  logic [TTW-1:0] tt_base [NBASE];

  wnd_cmd_pick u_pick (
    .do_save     (do_save),
    .do_restore  (do_restore),
    .do_flush    (do_flush),
    .do_saved    (do_saved),
    .do_restored (do_restored),
    .act         (act)
  );

  wnd_cwp_ring #(.NWIN(NWIN), .DW(DW)) u_ring (
    .cwp           (cwp_q),
    .wr_val        (wr_data),
    .cwp_inc       (cwp_inc),
    .cwp_dec       (cwp_dec),
    .cwp_view      (cwp_view),
    .cwp_from_view (cwp_wr)
  );

  // index 0 composes spill codes, index 1 fill codes
  for (genvar gi = 0; gi < NBASE; gi++) begin : g_tt
    wnd_trap_type #(.BASE(gi == 0 ? TT_SPILL : TT_FILL)) u_tt (
      .ws    (ws_q),
      .ow_nz (ow_q != '0),
      .tt    (tt_base[gi])
    );
  end

  assign sel = wsel_e'(wr_sel);

  always_comb begin
    cs_d  = cs_q;
    cr_d  = cr_q;
    ow_d  = ow_q;
    cl_d  = cl_q;
    ws_d  = ws_q;
    cwp_d = cwp_q;
    trv_d = 1'b0;
    trt_d = '0;
    if (wr_en) begin
      case (sel)
        SEL_CANSAVE: cs_d  = wr_data[CW-1:0];
        SEL_CANREST: cr_d  = wr_data[CW-1:0];
        SEL_OTHER:   ow_d  = wr_data[CW-1:0];
        SEL_CLEAN:   cl_d  = wr_data[CW-1:0];
        SEL_WSTATE:  ws_d  = wr_data[WSW-1:0];
        SEL_CWP:     cwp_d = cwp_wr;
        default: ;
      endcase
    end else begin
      case (act)
        ACT_SAVE: begin
          if (cs_q == '0) begin
            trv_d = 1'b1;
            trt_d = tt_base[0];
          end else if (cl_q == cr_q) begin
            trv_d = 1'b1;
            trt_d = TT_CLEAN;
          end else begin
            cs_d  = cs_q - CW'(1);
            cr_d  = cr_q + CW'(1);
            cwp_d = cwp_dec;
          end
        end
        ACT_RESTORE: begin
          if (cr_q == '0) begin
            trv_d = 1'b1;
            trt_d = tt_base[1];
          end else begin
            cs_d  = cs_q + CW'(1);
            cr_d  = cr_q - CW'(1);
            cwp_d = cwp_inc;
          end
        end
        ACT_FLUSH: begin
          if (cs_q != RST_CS) begin
            trv_d = 1'b1;
            trt_d = tt_base[0];
          end
        end
        ACT_SAVED: begin
          cs_d = cs_q + CW'(1);
          if (ow_q != '0) ow_d = ow_q - CW'(1);
          else            cr_d = cr_q - CW'(1);
        end
        ACT_RESTORED: begin
          cr_d = cr_q + CW'(1);
          if (cl_q < RST_CL) cl_d = cl_q + CW'(1);
          if (ow_q != '0) ow_d = ow_q - CW'(1);
          else            cs_d = cs_q - CW'(1);
        end
        default: ;
      endcase
    end
  end

  assign st_en = wr_en | (act != ACT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= RST_CS;
      cr_q  <= '0;
      ow_q  <= '0;
      cl_q  <= RST_CL;
      ws_q  <= '0;
      cwp_q <= '0;
      trv_q <= 1'b0;
      trt_q <= '0;
    end else begin
      trv_q <= trv_d;
      trt_q <= trt_d;
      if (st_en) begin
        cs_q  <= cs_d;
        cr_q  <= cr_d;
        ow_q  <= ow_d;
        cl_q  <= cl_d;
        ws_q  <= ws_d;
        cwp_q <= cwp_d;
      end
    end
  end

  assign cansave    = cs_q;
  assign canrestore = cr_q;
  assign otherwin   = ow_q;
  assign cleanwin   = cl_q;
  assign wstate     = ws_q;
  assign cwp_int    = cwp_q;
  assign cwp_sw     = cwp_view;
  assign trap_vld   = trv_q;
  assign trap_type  = trt_q;
endmodule

// File: rtl/wnd_ctr_unit_chk.sv
module wnd_ctr_unit_chk #(
  parameter int NWIN = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          do_save,
  input logic          do_restore,
  input logic          do_restored,
  input logic          wr_en,
  input logic [CW-1:0] cansave,
  input logic [CW-1:0] canrestore,
  input logic [CW-1:0] otherwin,
  input logic [CW-1:0] cleanwin,
  input logic [CW-1:0] cwp_int,
  input logic          trap_vld,
  input logic [8:0]    trap_type
);
  a_r2_spill_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (do_save && !wr_en && cansave == '0) |=> (trap_vld && trap_type[7:6] == 2'b10));

  a_r4_save_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (do_save && !wr_en && cansave != '0 && cleanwin != canrestore) |=>
      (!trap_vld && cansave == $past(cansave) - CW'(1)
       && canrestore == $past(canrestore) + CW'(1)));

  a_r5_fill_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (do_restore && !do_save && !wr_en && canrestore == '0) |=>
      (trap_vld && trap_type[7:6] == 2'b11));

  a_r9_trap_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    trap_vld |-> ($stable(cansave) && $stable(canrestore) && $stable(otherwin)
                  && $stable(cleanwin) && $stable(cwp_int)));

  a_r8_clean_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (do_restored && !do_save && !do_restore && !wr_en && cleanwin == CW'(NWIN - 1))
      |=> cleanwin == CW'(NWIN - 1));

  a_r10_cwp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cwp_int) < NWIN);
endmodule

bind wnd_ctr_unit wnd_ctr_unit_chk #(.NWIN(NWIN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .do_save     (do_save),
  .do_restore  (do_restore),
  .do_restored (do_restored),
  .wr_en       (wr_en),
  .cansave     (cansave),
  .canrestore  (canrestore),
  .otherwin    (otherwin),
  .cleanwin    (cleanwin),
  .cwp_int     (cwp_int),
  .trap_vld    (trap_vld),
  .trap_type   (trap_type)
);

// File: tb/tb_wnd_ctr_unit.sv
`timescale 1ns/1ps
module tb_wnd_ctr_unit;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       do_save, do_restore, do_flush, do_saved, do_restored, wr_en;
  logic [2:0] wr_sel;
  logic [7:0] wr_data;
  logic [2:0] cansave, canrestore, otherwin, cleanwin, cwp_int, cwp_sw;
  logic [5:0] wstate;
  logic       trap_vld;
  logic [8:0] trap_type;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  wnd_ctr_unit dut (
    .clk(clk), .rst_n(rst_n),
    .do_save(do_save), .do_restore(do_restore), .do_flush(do_flush),
    .do_saved(do_saved), .do_restored(do_restored),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cansave(cansave), .canrestore(canrestore), .otherwin(otherwin),
    .cleanwin(cleanwin), .wstate(wstate), .cwp_int(cwp_int), .cwp_sw(cwp_sw),
    .trap_vld(trap_vld), .trap_type(trap_type)
  );

  // reference state
  logic [2:0] m_cs, m_cr, m_ow, m_cl, m_cwp;
  logic [5:0] m_ws;
  logic       m_tv;
  logic [8:0] m_tt;

  function automatic logic [8:0] tt_of(input logic [8:0] base, input logic [2:0] ow,
                                       input logic [5:0] ws);
    if (ow != 0) return base | 9'h020 | {4'b0, ws[5:3], 2'b00};
    return base | {4'b0, ws[2:0], 2'b00};
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "cansave", cansave, m_cs);
    chk(tag, "canrestore", canrestore, m_cr);
    chk(tag, "otherwin", otherwin, m_ow);
    chk(tag, "cleanwin", cleanwin, m_cl);
    chk(tag, "wstate", wstate, m_ws);
    chk(tag, "cwp_int", cwp_int, m_cwp);
    chk(tag, "cwp_sw", cwp_sw, 3'(N - 1 - m_cwp));
    chk(tag, "trap_vld", trap_vld, m_tv);
    chk(tag, "trap_type", trap_type, m_tt);
  endtask

  task automatic model_step(input logic [4:0] c, input logic we, input logic [2:0] sel,
                            input logic [7:0] d);
    m_tv = 1'b0;
    m_tt = '0;
    if (we) begin
      case (sel)
        3'd0: m_cs = d[2:0];
        3'd1: m_cr = d[2:0];
        3'd2: m_ow = d[2:0];
        3'd3: m_cl = d[2:0];
        3'd4: m_ws = d[5:0];
        3'd5: m_cwp = 3'(N - 1 - (d % N));
        default: ;
      endcase
    end else if (c[0]) begin
      if (m_cs == 0) begin m_tv = 1; m_tt = tt_of(9'h080, m_ow, m_ws); end
      else if (m_cl == m_cr) begin m_tv = 1; m_tt = 9'h024; end
      else begin m_cs--; m_cr++; m_cwp = (m_cwp == 0) ? 3'(N - 1) : m_cwp - 1; end
    end else if (c[1]) begin
      if (m_cr == 0) begin m_tv = 1; m_tt = tt_of(9'h0C0, m_ow, m_ws); end
      else begin m_cs++; m_cr--; m_cwp = (m_cwp == 3'(N - 1)) ? 3'd0 : m_cwp + 1; end
    end else if (c[2]) begin
      if (m_cs != 3'(N - 2)) begin m_tv = 1; m_tt = tt_of(9'h080, m_ow, m_ws); end
    end else if (c[3]) begin
      m_cs++;
      if (m_ow != 0) m_ow--; else m_cr--;
    end else if (c[4]) begin
      m_cr++;
      if (m_cl < 3'(N - 1)) m_cl++;
      if (m_ow != 0) m_ow--; else m_cs--;
    end
  endtask

  // c bits: 0 save, 1 restore, 2 flush, 3 saved, 4 restored
  task automatic apply(input logic [4:0] c, input logic we, input logic [2:0] sel,
                       input logic [7:0] d, input string tag);
    {do_restored, do_saved, do_flush, do_restore, do_save} = c;
    wr_en = we; wr_sel = sel; wr_data = d;
    @(posedge clk);
    model_step(c, we, sel, d);
    @(negedge clk);
    {do_restored, do_saved, do_flush, do_restore, do_save} = '0;
    wr_en = 1'b0;
    chk_all(tag);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d, input string tag);
    apply(5'b0, 1'b1, sel, d, tag);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    {do_restored, do_saved, do_flush, do_restore, do_save} = '0;
    wr_en = 0; wr_sel = 0; wr_data = 0;
    rst_n = 0;
    m_cs = 3'(N - 2); m_cr = 0; m_ow = 0; m_cl = 3'(N - 1); m_ws = 0; m_cwp = 0;
    m_tv = 0; m_tt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_all("R1");

    // R2 spill composition, both sub-fields
    wr(3'd4, 8'h2B, "R11");
    wr(3'd0, 8'h00, "R11");
    apply(5'b00001, 0, 0, 0, "R2");
    chk("R2", "spill normal", trap_type, 9'h08C);
    wr(3'd2, 8'h02, "R11");
    apply(5'b00001, 0, 0, 0, "R2");
    chk("R2", "spill other", trap_type, 9'h0B4);
    apply(5'b00000, 0, 0, 0, "R9");
    chk("R9", "strobe drops", trap_vld, 0);
    // R5 fill
    wr(3'd1, 8'h00, "R11");
    apply(5'b00010, 0, 0, 0, "R5");
    chk("R5", "fill other", trap_type, 9'h0F4);
    wr(3'd2, 8'h00, "R11");
    apply(5'b00010, 0, 0, 0, "R5");
    chk("R5", "fill normal", trap_type, 9'h0CC);
    // R3 clean-window trap
    wr(3'd0, 8'h03, "R11");
    wr(3'd3, 8'h04, "R11");
    wr(3'd1, 8'h04, "R11");
    apply(5'b00001, 0, 0, 0, "R3");
    chk("R3", "clean trap", trap_type, 9'h024);
    // R4 pointer wrap down, R5 wrap up
    wr(3'd3, 8'h06, "R11");
    wr(3'd1, 8'h01, "R11");
    wr(3'd5, 8'h07, "R10");
    apply(5'b00001, 0, 0, 0, "R4");
    chk("R4", "cwp wrap", cwp_int, 7);
    apply(5'b00010, 0, 0, 0, "R5");
    chk("R5", "cwp wrap", cwp_int, 0);
    // R6 flush
    wr(3'd0, 8'h06, "R11");
    apply(5'b00100, 0, 0, 0, "R6");
    chk("R6", "flush quiet", trap_vld, 0);
    wr(3'd0, 8'h05, "R11");
    apply(5'b00100, 0, 0, 0, "R6");
    chk("R6", "flush trap", trap_vld, 1);
    // R7 saved, R13 wrap
    wr(3'd0, 8'h07, "R11");
    apply(5'b01000, 0, 0, 0, "R13");
    chk("R13", "cansave wrap", cansave, 0);
    wr(3'd2, 8'h03, "R11");
    apply(5'b01000, 0, 0, 0, "R7");
    chk("R7", "otherwin dec", otherwin, 2);
    // R8 restored with saturation
    wr(3'd3, 8'h07, "R11");
    apply(5'b10000, 0, 0, 0, "R8");
    chk("R8", "clean sat", cleanwin, 7);
    wr(3'd2, 8'h00, "R11");
    apply(5'b10000, 0, 0, 0, "R8");
    // R11 ignored selector and write-over-command
    wr(3'd6, 8'hFF, "R11");
    wr(3'd7, 8'hFF, "R11");
    apply(5'b00011, 1, 3'd4, 8'h15, "R11");
    chk("R11", "write wins", wstate, 6'h15);
    // R10 modulo pointer write
    wr(3'd5, 8'd13, "R10");
    chk("R10", "cwp_sw", cwp_sw, 5);
    chk("R10", "cwp_int", cwp_int, 2);
    // R12 priority
    wr(3'd0, 8'h02, "R11");
    wr(3'd1, 8'h02, "R11");
    wr(3'd3, 8'h05, "R11");
    apply(5'b11111, 0, 0, 0, "R12");
    apply(5'b11110, 0, 0, 0, "R12");
    apply(5'b11000, 0, 0, 0, "R12");

    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [4:0] c;
      r = $urandom % 16;
      if (r < 5) begin
        wr(3'($urandom), 8'($urandom), "R11");
      end else if (r < 7) begin
        c = 5'($urandom);
        apply(c, 0, 0, 0, "R12");
      end else begin
        c = 5'(1 << ($urandom % 5));
        apply(c, 0, 0, 0, c[0] ? "R4" : c[1] ? "R5" : c[2] ? "R6" : c[3] ? "R7" : "R8");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule